// File: doc/BRIEF.md
# Dual-Class Programmable Wait-State Generator

This block lengthens processor bus cycles by pulling the processor's ready input low for a set number of clocks. Two kinds of cycle have their own wait count. One is a fetch from the onboard boot memory. The other is a backplane I/O transfer or an interrupt-acknowledge cycle. Each count comes from a static 4-bit setting, and the usable range is 0 to 8 waits. A cycle that belongs to neither kind gets no added waits.

At the start of each cycle, the block decodes the cycle kind and loads a down-counter. Ready stays low while that counter holds a non-zero value. The ready output is re-registered on the falling clock edge. This gives the processor a full half period of setup time before its next sampling edge. Holding ready low keeps the bus cycle frozen for as long as it is held.

Top module: `dual_wait_gen`

## Requirements
- R1: After reset, and for as long as no cycle start is seen, ready_o is 1.
- R2: A cycle start with rom_sel_i=1 drives ready_o to 0 for exactly rom_waits_i clock periods. A setting of 0 adds no waits.
- R3: A cycle start with rom_sel_i=0 and either io_sel_i=1 or inta_i=1 drives ready_o to 0 for exactly io_waits_i clock periods.
- R4: A cycle start with rom_sel_i, io_sel_i and inta_i all 0 leaves ready_o at 1.
- R5: A count setting above 8 acts as 8.
- R6: When rom_sel_i and io_sel_i are both 1, the boot-memory count applies.
- R7: ready_o changes only on falling clock edges. After the rising edge that samples a start, ready_o first goes low at the following falling edge.
- R8: Each class uses only its own setting. The setting of the other class has no effect on the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | One-clock strobe marking the start of a decoded bus cycle |
| rom_sel_i | input | 1 | Cycle targets the boot memory |
| io_sel_i | input | 1 | Cycle is a backplane I/O transfer |
| inta_i | input | 1 | Cycle is an interrupt acknowledge |
| rom_waits_i | input | 4 | Boot-memory wait setting (0 to 8, larger values clamp) |
| io_waits_i | input | 4 | I/O and acknowledge wait setting (0 to 8, larger values clamp) |
| ready_o | output | 1 | Ready to the processor, registered on the falling edge |

## Verification
The vector table drives cycles of each class across the full range of settings: 0, 1, typical middle values, 8, and values above 8. Measuring the exact low time of ready tells an off-by-one count apart from a missing clamp. Some vectors set the two settings to different values. Those vectors show whether the right setting was chosen, whether rom_sel_i takes priority over io_sel_i, and whether an acknowledge cycle uses the I/O count. Directed cases cover the idle state after reset, and a sample taken just after the start edge, which shows whether ready moves on the falling edge rather than the rising edge.

// File: rtl/wait_pkg.sv
package wait_pkg;
  localparam int unsigned SET_W     = 4;
  localparam int unsigned MAX_WAITS = 8;
  localparam int unsigned CNT_W     = $clog2(MAX_WAITS + 1);

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ROM  = 2'd1,
    CLS_IO   = 2'd2
  } cyc_cls_e;

  function automatic logic [CNT_W-1:0] clamp_waits(input logic [SET_W-1:0] w);
    if (w > SET_W'(MAX_WAITS)) return CNT_W'(MAX_WAITS);
    return CNT_W'(w);
  endfunction
endpackage

// File: rtl/wait_class_sel.sv
module wait_class_sel
  import wait_pkg::*;
(
  input  logic             rom_sel_i,
  input  logic             io_sel_i,
  input  logic             inta_i,
  input  logic [SET_W-1:0] rom_waits_i,
  input  logic [SET_W-1:0] io_waits_i,
  output cyc_cls_e         cls_o,
  output logic [CNT_W-1:0] load_val_o
);
  // boot memory decode wins over I/O
  always_comb begin
    if (rom_sel_i)                cls_o = CLS_ROM;
    else if (io_sel_i || inta_i)  cls_o = CLS_IO;
    else                          cls_o = CLS_NONE;
  end

  always_comb begin
    unique case (cls_o)
      CLS_ROM: load_val_o = clamp_waits(rom_waits_i);
      CLS_IO:  load_val_o = clamp_waits(io_waits_i);
      default: load_val_o = '0;
    endcase
  end
endmodule

// File: rtl/wait_down_cnt.sv
module wait_down_cnt
  import wait_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ready_negedge_reg.sv
module ready_negedge_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic rdy_o
);
  // falling-edge stage gives half a period of setup to the CPU
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_o <= 1'b1;
    else         rdy_o <= rdy_i;
  end
endmodule

// File: rtl/dual_wait_gen.sv
module dual_wait_gen
  import wait_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_start_i,
  input  logic             rom_sel_i,
  input  logic             io_sel_i,
  input  logic             inta_i,
  input  logic [SET_W-1:0] rom_waits_i,
  input  logic [SET_W-1:0] io_waits_i,
  output logic             ready_o
);
  cyc_cls_e         cls;
  logic [CNT_W-1:0] load_val;
  logic             busy;

  wait_class_sel u_sel (
    .rom_sel_i   (rom_sel_i),
    .io_sel_i    (io_sel_i),
    .inta_i      (inta_i),
    .rom_waits_i (rom_waits_i),
    .io_waits_i  (io_waits_i),
    .cls_o       (cls),
    .load_val_o  (load_val)
  );

  wait_down_cnt u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cyc_start_i),
    .load_val_i (load_val),
    .busy_o     (busy)
  );

  ready_negedge_reg u_rdy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (~busy),
    .rdy_o  (ready_o)
  );
endmodule

// File: rtl/dual_wait_gen_chk.sv
module dual_wait_gen_chk
  import wait_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_start_i,
  input logic             rom_sel_i,
  input logic             io_sel_i,
  input logic             inta_i,
  input logic [SET_W-1:0] rom_waits_i,
  input logic [SET_W-1:0] io_waits_i,
  input logic             ready_o
);
  a_r1_idle_stays_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cyc_start_i) |=> ready_o);

  a_r2_rom_zero_no_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && rom_sel_i && rom_waits_i == '0) |=> ready_o);

  a_r2_rom_wait_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && rom_sel_i && rom_waits_i != '0) |=> !ready_o);

  a_r3_io_wait_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !rom_sel_i && (io_sel_i || inta_i) && io_waits_i != '0) |=> !ready_o);

  a_r4_no_class_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !rom_sel_i && !io_sel_i && !inta_i) |=> ready_o);
endmodule

bind dual_wait_gen dual_wait_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .rom_sel_i   (rom_sel_i),
  .io_sel_i    (io_sel_i),
  .inta_i      (inta_i),
  .rom_waits_i (rom_waits_i),
  .io_waits_i  (io_waits_i),
  .ready_o     (ready_o)
);

// File: tb/sim_dual_wait_gen.sv
`timescale 1ns/1ps
module sim_dual_wait_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_start_i = 1'b0;
  logic       rom_sel_i = 1'b0;
  logic       io_sel_i = 1'b0;
  logic       inta_i = 1'b0;
  logic [3:0] rom_waits_i = 4'd0;
  logic [3:0] io_waits_i = 4'd0;
  logic       ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_wait_gen u0 (.*);

  // {rom, io, inta, rom_waits, io_waits, expected low clocks}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {3'b100, 4'd3,  4'd2,  4'd3},   // R2 typical
    {3'b100, 4'd0,  4'd5,  4'd0},   // R2 zero
    {3'b100, 4'd1,  4'd0,  4'd1},   // R2 one
    {3'b100, 4'd8,  4'd0,  4'd8},   // R2 max
    {3'b010, 4'd3,  4'd2,  4'd2},   // R3 io typical
    {3'b001, 4'd7,  4'd4,  4'd4},   // R3 inta
    {3'b010, 4'd6,  4'd0,  4'd0},   // R3 zero
    {3'b000, 4'd8,  4'd8,  4'd0},   // R4 no class
    {3'b100, 4'd15, 4'd1,  4'd8},   // R5 rom clamp
    {3'b010, 4'd0,  4'd9,  4'd8},   // R5 io clamp
    {3'b110, 4'd1,  4'd6,  4'd1},   // R6 priority
    {3'b010, 4'd8,  4'd1,  4'd1},   // R8 rom setting ignored
    {3'b100, 4'd2,  4'd8,  4'd2}    // R8 io setting ignored
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start a cycle, return the number of clocks ready_o is low
  task automatic run_cycle(input logic [2:0] cls, input logic [3:0] rw,
                           input logic [3:0] iw, output int low, output bit early);
    @(negedge clk_i);
    {rom_sel_i, io_sel_i, inta_i} = cls;
    rom_waits_i = rw;
    io_waits_i  = iw;
    cyc_start_i = 1'b1;
    @(posedge clk_i);
    #1 early = ~ready_o;
    @(negedge clk_i);
    cyc_start_i = 1'b0;
    {rom_sel_i, io_sel_i, inta_i} = 3'b000;
    low = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_i);
      #1;
      if (ready_o) break;
      low++;
    end
  endtask

  initial begin
    int  low;
    bit  early;
    repeat (3) @(posedge clk_i);
    #1 chk(ready_o === 1'b1, "R1 ready in reset", int'(ready_o), 1);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #1 chk(ready_o === 1'b1, "R1 idle after reset", int'(ready_o), 1);

    for (int i = 0; i < NV; i++) begin
      run_cycle(VEC[i][14:12], VEC[i][11:8], VEC[i][7:4], low, early);
      chk(low == int'(VEC[i][3:0]), $sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i),
          low, int'(VEC[i][3:0]));
    end

    // R7: not low right after the rising edge, low by the falling edge
    run_cycle(3'b100, 4'd2, 4'd0, low, early);
    chk(!early, "R7 unchanged at rising edge", int'(early), 0);
    chk(low == 2, "R7 low span", low, 2);
    @(negedge clk_i);
    cyc_start_i = 1'b1; rom_sel_i = 1'b1; rom_waits_i = 4'd4;
    @(negedge clk_i);
    cyc_start_i = 1'b0; rom_sel_i = 1'b0;
    #1 chk(ready_o === 1'b0, "R7 low after falling edge", int'(ready_o), 0);
    repeat (6) @(posedge clk_i);
    #1 chk(ready_o === 1'b1, "R1 ready again when idle", int'(ready_o), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule